// File: doc/BRIEF.md
# BCD Calendar Clock with Snapshot Read and Staged Commit

This block keeps time of day and calendar date in binary-coded decimal. A one-cycle enable pulse, once per second and derived elsewhere from a 32.768 kHz timebase, advances a chain of counters. The chain covers seconds, minutes and hours, either in 24-hour form or in 12-hour form with a PM flag. It also covers day of week, date, month and a two-digit year. Month lengths and leap years are handled for the years 2000 to 2099.

A host bus reaches the time through two separate paths. To read, the host first requests a snapshot, which copies the whole live time into a holding latch in one cycle. The host then reads bytes from that latch while the live counters keep running. To write, the host fills an eight-byte staging buffer and then signals the end of the transaction. A commit pulse (a valid stop) arms a load only if all eight bytes were written. The armed load replaces the live time at the next second pulse. An abort, or a commit after an incomplete page, throws the staged page away.

After reset the clock is halted. It starts counting only once a committed page has been loaded.

Top module: `rtc_cal_clock`

## Requirements
- R1: After reset the live time and the snapshot both read seconds 00h, minutes 00h, hour 80h (24-hour mode, hour 00), date 01h, month 01h, year 00h and day of week 00h, and `halted` is 1. The byte addresses are 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week and 7 spare. The spare byte resets to 00h and holds whatever is loaded into it.
- R2: While `halted` is 1, second pulses do not change the time. `halted` falls when a committed page is loaded and never rises again until reset.
- R3: Seconds and minutes count 00h to 59h in BCD and carry on the wrap. In 24-hour mode (hour bit 7 = 1) the hour counts 00h to 23h in bits 5:0, and 23:59:59 wraps to 00:00:00 with a day advance.
- R4: In 12-hour mode (hour bit 7 = 0), hour bits 4:0 count 01h to 12h and bit 5 is the PM flag. 11:59:59 moves to 12:00:00 and toggles PM. 12:59:59 moves to 01:00:00 with PM unchanged. Only the step from 11 PM to 12 AM advances the day.
- R5: After their last day, months 04h, 06h, 09h and 11h roll over from date 30h to the first of the next month. All other months except February roll over from date 31h. Month 12h rolls to month 01h and advances the year.
- R6: February has 29 days when the BCD year is divisible by 4 and 28 days otherwise. Year 99h wraps to 00h.
- R7: The day of week counts 0 to 6. It advances on every day rollover and wraps from 6 to 0, independently of the date.
- R8: A `snap_req` pulse copies all eight live bytes into the snapshot. The value copied is the one held before any second pulse in the same cycle. `rd_data` returns snapshot byte `rd_addr`, and it does not change when the live time advances.
- R9: When all eight addresses have been written since the last commit or abort, a `commit` pulse arms a load. The live time stays unchanged until the next second pulse. At that pulse the live time becomes exactly the staged page, without advancing.
- R10: A `commit` after fewer than eight distinct addresses have been written, or any `abort`, discards the staged page. The running time is left untouched.
- R11: Staging writes never disturb the live counters, which keep advancing on second pulses while a page is being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| snap_req | input | 1 | Copy live time into the snapshot latch |
| wr_en | input | 1 | Staging byte write strobe |
| wr_addr | input | 3 | Staging byte address 0 to 7 |
| wr_data | input | 8 | Staging byte value |
| commit | input | 1 | Valid end of write transaction |
| abort | input | 1 | Invalid end of write transaction |
| rd_addr | input | 3 | Snapshot byte address 0 to 7 |
| rd_data | output | 8 | Snapshot byte |
| halted | output | 1 | Clock not yet started since reset |

## Verification
Two cases can fall into one cycle, and the bench forces both. The first is a snapshot request arriving on the same cycle as a second pulse. The bench drives both on one cycle and expects the snapshot to hold the time from before the pulse, with the next snapshot showing the advanced time. The second is a commit arriving together with a second pulse. That pulse must advance the old time normally, and the staged page must appear only at the following pulse. The bench also covers the load itself coinciding with a snapshot request: the snapshot keeps the pre-load time and the live counters take the page.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int unsigned SLOT_CNT = 8;
   localparam int unsigned I_SEC    = 0;
   localparam int unsigned I_MIN    = 1;
   localparam int unsigned I_HOUR   = 2;
   localparam int unsigned I_DATE   = 3;
   localparam int unsigned I_MON    = 4;
   localparam int unsigned I_YEAR   = 5;
   localparam int unsigned I_DOW    = 6;
   localparam int unsigned I_SPARE  = 7;

   typedef logic [SLOT_CNT-1:0][7:0] bank_t;

   // Two-digit BCD increment without wrap handling.
   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
      return {v[7:4], v[3:0] + 4'd1};
   endfunction

   function automatic logic year_is_leap(input logic [7:0] y);
      logic [7:0] b;
      b = ({4'b0, y[7:4]} * 8'd10) + {4'b0, y[3:0]};
      return (b[1:0] == 2'b00);
   endfunction

   function automatic logic [7:0] last_date(input logic [7:0] m, input logic [7:0] y);
      case (m)
         8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   // Returns {day_carry, next_hour_byte}.
   function automatic logic [8:0] hour_step(input logic [7:0] h);
      logic [7:0] v;
      if (h[7]) begin
         if (h[5:0] == 6'h23) return {1'b1, 8'h80};
         v = bcd_inc({2'b00, h[5:0]});
         return {1'b0, 1'b1, 1'b0, v[5:0]};
      end
      v = {3'b000, h[4:0]};
      if (v == 8'h11) return {h[5], 2'b00, ~h[5], 5'h12};
      if (v == 8'h12) return {1'b0, 2'b00, h[5], 5'h01};
      v = bcd_inc(v);
      return {1'b0, 2'b00, h[5], v[4:0]};
   endfunction

   function automatic bank_t advance(input bank_t t);
      bank_t      n;
      logic [8:0] hs;
      logic       day;
      n   = t;
      hs  = '0;
      day = 1'b0;
      if (t[I_SEC] != 8'h59) n[I_SEC] = bcd_inc(t[I_SEC]);
      else begin
         n[I_SEC] = 8'h00;
         if (t[I_MIN] != 8'h59) n[I_MIN] = bcd_inc(t[I_MIN]);
         else begin
            n[I_MIN]  = 8'h00;
            hs        = hour_step(t[I_HOUR]);
            n[I_HOUR] = hs[7:0];
            day       = hs[8];
         end
      end
      if (day) begin
         n[I_DOW] = (t[I_DOW] >= 8'h06) ? 8'h00 : t[I_DOW] + 8'h01;
         if (t[I_DATE] != last_date(t[I_MON], t[I_YEAR])) n[I_DATE] = bcd_inc(t[I_DATE]);
         else begin
            n[I_DATE] = 8'h01;
            if (t[I_MON] != 8'h12) n[I_MON] = bcd_inc(t[I_MON]);
            else begin
               n[I_MON]  = 8'h01;
               n[I_YEAR] = (t[I_YEAR] == 8'h99) ? 8'h00 : bcd_inc(t[I_YEAR]);
            end
         end
      end
      return n;
   endfunction

   function automatic bank_t reset_bank(input bit mode24);
      bank_t b;
      b         = '0;
      b[I_HOUR] = mode24 ? 8'h80 : 8'h12;
      b[I_DATE] = 8'h01;
      b[I_MON]  = 8'h01;
      return b;
   endfunction

endpackage

// File: rtl/rtc_cal_stage.sv
module rtc_cal_stage
   import rtc_cal_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 8,
   parameter int unsigned ADDR_W    = $clog2(NUM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              commit,
   input  logic              abort,
   input  logic              apply,
   output bank_t             stage_o,
   output logic              pending_o
);

   logic [7:0]           slot_q [NUM_BYTES];
   logic [NUM_BYTES-1:0] have_q;
   logic                 pend_q;

   for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                                       slot_q[g] <= 8'h00;
         else if (wr_en && (wr_addr == ADDR_W'(g)))         slot_q[g] <= wr_data;
      end
      assign stage_o[g] = slot_q[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_q <= '0;
         pend_q <= 1'b0;
      end else begin
         if (commit || abort) have_q <= '0;
         else if (wr_en)      have_q[wr_addr] <= 1'b1;
         if (commit && (&have_q)) pend_q <= 1'b1;
         else if (apply)          pend_q <= 1'b0;
      end
   end

   assign pending_o = pend_q;

endmodule

// File: rtl/rtc_cal_live.sv
module rtc_cal_live
   import rtc_cal_pkg::*;
#(
   parameter bit RESET_24H = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick,
   input  logic  run,
   input  logic  apply,
   input  bank_t load_val,
   output bank_t live_o
);

   bank_t live_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             live_q <= reset_bank(RESET_24H);
      else if (apply)         live_q <= load_val;
      else if (tick && run)   live_q <= advance(live_q);
   end

   assign live_o = live_q;

endmodule

// File: rtl/rtc_cal_snap.sv
module rtc_cal_snap
   import rtc_cal_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 8,
   parameter int unsigned ADDR_W    = $clog2(NUM_BYTES),
   parameter bit          RESET_24H = 1'b1,
   parameter bit          READ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_req,
   input  bank_t             live_i,
   input  logic [ADDR_W-1:0] rd_addr,
   output bank_t             snap_o,
   output logic [7:0]        rd_data
);

   bank_t snap_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        snap_q <= reset_bank(RESET_24H);
      else if (snap_req) snap_q <= live_i;
   end

   assign snap_o = snap_q;

   if (READ_REG) begin : g_rd_reg
      logic [7:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rd_q <= 8'h00;
         else        rd_q <= snap_q[rd_addr];
      end
      assign rd_data = rd_q;
   end else begin : g_rd_comb
      assign rd_data = snap_q[rd_addr];
   end

endmodule

// File: rtl/rtc_cal_clock.sv
module rtc_cal_clock
   import rtc_cal_pkg::*;
#(
   parameter int unsigned NUM_BYTES = 8,
   parameter int unsigned BYTE_W    = 8,
   parameter bit          RESET_24H = 1'b1,
   parameter bit          READ_REG  = 1'b0,
   parameter int unsigned ADDR_W    = $clog2(NUM_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              snap_req,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              commit,
   input  logic              abort,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data,
   output logic              halted
);

   if (NUM_BYTES != SLOT_CNT) begin : g_bad_count
      $error("rtc_cal_clock: NUM_BYTES must equal the package slot count");
   end
   if (BYTE_W != 8) begin : g_bad_width
      $error("rtc_cal_clock: BYTE_W must be 8 for BCD fields");
   end
   if (ADDR_W != $clog2(NUM_BYTES)) begin : g_bad_addr
      $error("rtc_cal_clock: ADDR_W inconsistent with NUM_BYTES");
   end

   bank_t stage_q;
   bank_t live_q;
   bank_t snap_q;
   logic  pend_q;
   logic  halt_q;
   logic  apply;

   assign apply = tick_1hz && pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     halt_q <= 1'b1;
      else if (apply) halt_q <= 1'b0;
   end

   rtc_cal_stage #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .commit    (commit),
      .abort     (abort),
      .apply     (apply),
      .stage_o   (stage_q),
      .pending_o (pend_q)
   );

   rtc_cal_live #(.RESET_24H(RESET_24H)) u_live (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_1hz),
      .run      (!halt_q),
      .apply    (apply),
      .load_val (stage_q),
      .live_o   (live_q)
   );

   rtc_cal_snap #(
      .NUM_BYTES (NUM_BYTES),
      .ADDR_W    (ADDR_W),
      .RESET_24H (RESET_24H),
      .READ_REG  (READ_REG)
   ) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .snap_req (snap_req),
      .live_i   (live_q),
      .rd_addr  (rd_addr),
      .snap_o   (snap_q),
      .rd_data  (rd_data)
   );

   assign halted = halt_q;

endmodule

// File: rtl/rtc_cal_clock_chk.sv
module rtc_cal_clock_chk
   import rtc_cal_pkg::*;
(
   input logic  clk,
   input logic  rst_n,
   input logic  tick_1hz,
   input logic  snap_req,
   input logic  halted,
   input logic  pending,
   input bank_t live,
   input bank_t snap,
   input bank_t stage
);

   // R2: a halted clock with nothing armed keeps its time
   p_halt_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !pending) |=> $stable(live));

   // R2: once running, never halted again
   p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !halted |=> !halted);

   // R11: live time only moves on a second pulse
   p_tick_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_1hz |=> $stable(live));

   // R9: armed page lands verbatim at the second pulse
   p_load_exact_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && pending) |=> (live == $past(stage)) && !halted);

   // R8: snapshot copies pre-edge live time
   p_snap_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> (snap == $past(live)));

   // R8: snapshot frozen without a request
   p_snap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_req |=> $stable(snap));

   // R3: seconds remain a legal BCD value
   p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live[I_SEC][3:0] <= 4'd9) && (live[I_SEC] <= 8'h59));

   // R7: day of week stays within 0..6
   p_dow_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      live[I_DOW] <= 8'h06);

endmodule

bind rtc_cal_clock rtc_cal_clock_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_1hz (tick_1hz),
   .snap_req (snap_req),
   .halted   (halted),
   .pending  (pend_q),
   .live     (live_q),
   .snap     (snap_q),
   .stage    (stage_q)
);

// File: tb/rtc_cal_clock_test.sv
module rtc_cal_clock_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       snap_req = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       commit = 1'b0;
   logic       abort = 1'b0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       halted;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rtc_cal_clock uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_1hz (tick_1hz),
      .snap_req (snap_req),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .commit   (commit),
      .abort    (abort),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .halted   (halted)
   );

   function automatic logic [63:0] mk(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                                      logic [7:0] d, logic [7:0] mo, logic [7:0] y,
                                      logic [7:0] w);
      return {8'h00, w, y, mo, d, h, m, s};
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic read_snap(output logic [63:0] v);
      for (int i = 0; i < 8; i++) begin
         rd_addr = 3'(i);
         #0.5;
         v[8*i +: 8] = rd_data;
      end
   endtask

   task automatic take(output logic [63:0] v);
      @(negedge clk) snap_req = 1'b1;
      @(negedge clk) snap_req = 1'b0;
      read_snap(v);
   endtask

   task automatic tick();
      @(negedge clk) tick_1hz = 1'b1;
      @(negedge clk) tick_1hz = 1'b0;
   endtask

   task automatic write_bytes(logic [63:0] b, int first, int last);
      for (int i = first; i <= last; i++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = 3'(i); wr_data = b[8*i +: 8];
      end
      @(negedge clk) wr_en = 1'b0;
   endtask

   task automatic pulse_commit();
      @(negedge clk) commit = 1'b1;
      @(negedge clk) commit = 1'b0;
   endtask

   task automatic load(logic [63:0] b);
      write_bytes(b, 0, 7);
      pulse_commit();
      tick();
   endtask

   task automatic t_reset();
      logic [63:0] v;
      @(negedge clk);
      read_snap(v);
      check("R1", "reset snapshot", v, mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00));
      check("R1", "reset halted", {63'b0, halted}, 64'd1);
      take(v);
      check("R1", "reset live", v, mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00));
   endtask

   task automatic t_halt();
      logic [63:0] v;
      repeat (3) tick();
      take(v);
      check("R2", "halted ignores ticks", v, mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00));
   endtask

   task automatic t_load_and_wrap();
      logic [63:0] v;
      logic [63:0] p;
      p = mk(8'h58, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06);
      write_bytes(p, 0, 7);
      pulse_commit();
      take(v);
      check("R9", "no load before tick", v, mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00));
      check("R2", "still halted before load", {63'b0, halted}, 64'd1);
      tick();
      take(v);
      check("R9", "page loaded exactly", v, p);
      check("R2", "halted cleared by load", {63'b0, halted}, 64'd0);
      tick();
      take(v);
      check("R3", "second advance", v, mk(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h06));
      tick();
      take(v);
      check("R6", "new year 99->00, R3 day wrap, R7 dow 6->0", v,
            mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00));
   endtask

   task automatic t_snap_freeze();
      logic [63:0] v;
      repeat (2) tick();
      read_snap(v);
      check("R8", "snapshot frozen across ticks", v, mk(8'h00, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00));
      take(v);
      check("R8", "fresh snapshot", v, mk(8'h02, 8'h00, 8'h80, 8'h01, 8'h01, 8'h00, 8'h00));
   endtask

   task automatic t_12h();
      logic [63:0] v;
      load(mk(8'h59, 8'h59, 8'h11, 8'h15, 8'h06, 8'h24, 8'h02));
      tick();
      take(v);
      check("R4", "11 AM -> 12 PM", v, mk(8'h00, 8'h00, 8'h32, 8'h15, 8'h06, 8'h24, 8'h02));
      load(mk(8'h59, 8'h59, 8'h32, 8'h15, 8'h06, 8'h24, 8'h02));
      tick();
      take(v);
      check("R4", "12 PM -> 1 PM", v, mk(8'h00, 8'h00, 8'h21, 8'h15, 8'h06, 8'h24, 8'h02));
      load(mk(8'h59, 8'h59, 8'h31, 8'h15, 8'h06, 8'h24, 8'h02));
      tick();
      take(v);
      check("R4", "11 PM -> 12 AM next day, R7", v, mk(8'h00, 8'h00, 8'h12, 8'h16, 8'h06, 8'h24, 8'h03));
   endtask

   task automatic day_case(string req, string what, logic [7:0] d, logic [7:0] mo,
                           logic [7:0] y, logic [7:0] ed, logic [7:0] emo, logic [7:0] ey);
      logic [63:0] v;
      load(mk(8'h59, 8'h59, 8'hA3, d, mo, y, 8'h01));
      tick();
      take(v);
      check(req, what, v, mk(8'h00, 8'h00, 8'h80, ed, emo, ey, 8'h02));
   endtask

   task automatic t_months();
      day_case("R5", "Apr 30 -> May 1", 8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
      day_case("R5", "May 30 -> May 31", 8'h30, 8'h05, 8'h24, 8'h31, 8'h05, 8'h24);
      day_case("R5", "Sep 30 -> Oct 1", 8'h30, 8'h09, 8'h24, 8'h01, 8'h10, 8'h24);
      day_case("R5", "Nov 30 -> Dec 1", 8'h30, 8'h11, 8'h24, 8'h01, 8'h12, 8'h24);
      day_case("R5", "Jul 31 -> Aug 1", 8'h31, 8'h07, 8'h24, 8'h01, 8'h08, 8'h24);
   endtask

   task automatic t_leap();
      day_case("R6", "2024 Feb 28 -> 29", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
      day_case("R6", "2024 Feb 29 -> Mar 1", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
      day_case("R6", "2023 Feb 28 -> Mar 1", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
      day_case("R6", "2000 Feb 28 -> 29", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
      day_case("R6", "2012 Feb 28 -> 29", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02, 8'h12);
      day_case("R6", "2010 Feb 28 -> Mar 1", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03, 8'h10);
   endtask

   task automatic t_bad_write();
      logic [63:0] v;
      logic [63:0] p;
      p = mk(8'h00, 8'h00, 8'h90, 8'h10, 8'h10, 8'h30, 8'h05);
      load(mk(8'h10, 8'h20, 8'h85, 8'h05, 8'h05, 8'h25, 8'h04));
      write_bytes(p, 0, 6);
      pulse_commit();
      tick();
      take(v);
      check("R10", "short page discarded", v, mk(8'h11, 8'h20, 8'h85, 8'h05, 8'h05, 8'h25, 8'h04));
      write_bytes(p, 0, 7);
      @(negedge clk) abort = 1'b1;
      @(negedge clk) abort = 1'b0;
      pulse_commit();
      tick();
      take(v);
      check("R10", "aborted page discarded", v, mk(8'h12, 8'h20, 8'h85, 8'h05, 8'h05, 8'h25, 8'h04));
   endtask

   task automatic t_overlap();
      logic [63:0] v;
      logic [63:0] p;
      p = mk(8'h00, 8'h00, 8'h90, 8'h10, 8'h10, 8'h30, 8'h05);
      write_bytes(p, 0, 3);
      tick();
      take(v);
      check("R11", "running during staging", v, mk(8'h13, 8'h20, 8'h85, 8'h05, 8'h05, 8'h25, 8'h04));
      write_bytes(p, 4, 7);
      @(negedge clk) begin commit = 1'b1; tick_1hz = 1'b1; end
      @(negedge clk) begin commit = 1'b0; tick_1hz = 1'b0; end
      take(v);
      check("R9", "commit+tick advances old time", v, mk(8'h14, 8'h20, 8'h85, 8'h05, 8'h05, 8'h25, 8'h04));
      @(negedge clk) begin snap_req = 1'b1; tick_1hz = 1'b1; end
      @(negedge clk) begin snap_req = 1'b0; tick_1hz = 1'b0; end
      read_snap(v);
      check("R8", "snap+tick holds pre-tick time", v, mk(8'h14, 8'h20, 8'h85, 8'h05, 8'h05, 8'h25, 8'h04));
      take(v);
      check("R9", "page applied at next tick", v, p);
      tick();
      take(v);
      check("R3", "loaded page keeps running", v, mk(8'h01, 8'h00, 8'h90, 8'h10, 8'h10, 8'h30, 8'h05));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_halt();
      t_load_and_wrap();
      t_snap_freeze();
      t_12h();
      t_months();
      t_leap();
      t_bad_write();
      t_overlap();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule